// File: doc/BRIEF.md
# Register Scoreboard with Bypass Readiness

This block keeps one pending-result flag for each general register of a processor core. When an instruction that writes a register is issued and granted, the flag of its destination goes up. When a write port of the register set delivers that register's value, the flag comes down. Up to two write ports can deliver results in the same cycle.

For each candidate instruction the issue logic presents two source register numbers and one destination register number, each with a flag saying whether that field is used. The scoreboard answers in the same cycle whether the operands can be obtained. An operand counts as obtainable when its flag is low, or when its value is arriving on a write port in this very cycle and can be taken from the crossbar. This lets a dependent instruction follow its producer with no gap.

The grant is the issue request qualified by that readiness. Register 0 is hardwired: it never becomes pending and is always ready.

Top module: `regscore_top`

## Requirements
- R1: A cycle with `rst` high clears every pending flag, including when an issue is granted in that same cycle; `busy_vec` reads all zeros after that edge.
- R2: A granted issue with `dst_use` high and a nonzero `dst` sets bit `dst` of `busy_vec` from the next cycle on.
- R3: A write on port k (`wb_en[k]` high, register number in `wb_reg[k*AW +: AW]`) clears that register's bit from the next cycle on. Both ports can clear different registers in the same cycle.
- R4: `ops_ready` is low while any used source names a pending register that no enabled write port delivers in that cycle. In that case `issue_grant` is low and the destination flag is left unchanged.
- R5: A used source whose register is pending counts as ready when an enabled write port on either port delivers that register in the same cycle.
- R6: A source whose use flag is low does not affect `ops_ready`, whatever register number it carries.
- R7: Register 0 as a source is always ready, and as a destination it is never flagged.
- R8: When a granted issue sets a register and a write port clears the same register in one cycle, the register is pending afterwards.
- R9: `issue_grant` equals `issue_req` AND `ops_ready`. Without a grant no flag is set, even when `ops_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_req | input | 1 | Candidate instruction wants to issue |
| src_a | input | AW | First source register number |
| src_a_use | input | 1 | First source is used |
| src_b | input | AW | Second source register number |
| src_b_use | input | 1 | Second source is used |
| dst | input | AW | Destination register number |
| dst_use | input | 1 | Instruction writes a destination |
| wb_en | input | NWP | Per write port: a register write lands this cycle |
| wb_reg | input | NWP*AW | Register numbers of the write ports, port k at bits k*AW +: AW |
| ops_ready | output | 1 | All used sources can be obtained this cycle |
| issue_grant | output | 1 | Issue accepted this cycle |
| busy_vec | output | NREG | Registered pending flags, bit i for register i |

## Verification
The bench builds the block with 16 registers and two write ports. With that size, the highest register number (15) can be used as a source, a destination and a write target within a short run. A sequence of vectors walks through a stall on a pending source, a release through the crossbar on each port separately, and an unused source carrying a pending number. It also covers register 0 on every field, a set and a clear landing on the same register, and two clears in one cycle. Directed steps then check reset while an issue is being granted.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_NUM_SRC = 2;
  localparam int SB_NUM_WP  = 2;
endpackage

// File: rtl/sb_src_check.sv
module sb_src_check #(
  parameter int NREG = 64,
  parameter int AW   = $clog2(NREG),
  parameter int NWP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     src_idx,
  input  logic              src_use,
  input  logic [NREG-1:0]   busy,
  input  logic [NWP-1:0]    wb_en,
  input  logic [NWP*AW-1:0] wb_reg,
  output logic              src_ok
);
  logic [NWP-1:0] hit;
  logic           bypass;
  logic           is_zero;

  generate
    for (genvar k = 0; k < NWP; k++) begin : g_port
      assign hit[k] = wb_en[k] && (wb_reg[k*AW +: AW] == src_idx);
    end
  endgenerate

  assign bypass  = |hit;
  assign is_zero = (src_idx == '0);

  always_comb begin
    if (!src_use || is_zero) src_ok = 1'b1;
    else                     src_ok = !busy[src_idx] || bypass;
  end

  assert_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (src_use && busy[src_idx] && (wb_en == '0)) |-> !src_ok);
  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (src_use && wb_en[0] && (wb_reg[AW-1:0] == src_idx)) |-> src_ok);
  assert_unused_R6: assert property (@(posedge clk) disable iff (rst)
    !src_use |-> src_ok);
  assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (src_idx == '0) |-> src_ok);
endmodule

// File: rtl/sb_busy_bank.sv
module sb_busy_bank #(
  parameter int NREG = 64,
  parameter int AW   = $clog2(NREG),
  parameter int NWP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [AW-1:0]     set_idx,
  input  logic [NWP-1:0]    clr_en,
  input  logic [NWP*AW-1:0] clr_idx,
  output logic [NREG-1:0]   busy
);
  assign busy[0] = 1'b0;

  generate
    for (genvar i = 1; i < NREG; i++) begin : g_reg
      logic [NWP-1:0] clr_hit;
      logic           set_hit;
      logic           flag_q;
      for (genvar k = 0; k < NWP; k++) begin : g_clr
        assign clr_hit[k] = clr_en[k] && (clr_idx[k*AW +: AW] == AW'(i));
      end
      assign set_hit = set_en && (set_idx == AW'(i));
      always_ff @(posedge clk) begin
        if (rst)            flag_q <= 1'b0;
        else if (set_hit)   flag_q <= 1'b1;
        else if (|clr_hit)  flag_q <= 1'b0;
      end
      assign busy[i] = flag_q;
    end
  endgenerate

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (busy == '0));
  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (set_en && (set_idx != '0)) |=> busy[$past(set_idx)]);

  generate
    for (genvar k = 0; k < NWP; k++) begin : g_chk
      assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_en[k] && !(set_en && (set_idx == clr_idx[k*AW +: AW])))
        |=> !busy[$past(clr_idx[k*AW +: AW])]);
      assert_setwins_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_en[k] && set_en && (set_idx == clr_idx[k*AW +: AW]) && (set_idx != '0))
        |=> busy[$past(set_idx)]);
    end
  endgenerate
endmodule

// File: rtl/regscore_top.sv
module regscore_top #(
  parameter int NREG = 64,
  parameter int AW   = $clog2(NREG),
  parameter int NWP  = sb_pkg::SB_NUM_WP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_req,
  input  logic [AW-1:0]     src_a,
  input  logic              src_a_use,
  input  logic [AW-1:0]     src_b,
  input  logic              src_b_use,
  input  logic [AW-1:0]     dst,
  input  logic              dst_use,
  input  logic [NWP-1:0]    wb_en,
  input  logic [NWP*AW-1:0] wb_reg,
  output logic              ops_ready,
  output logic              issue_grant,
  output logic [NREG-1:0]   busy_vec
);
  localparam int NSRC = sb_pkg::SB_NUM_SRC;

  logic [AW-1:0]   src_idx [NSRC];
  logic [NSRC-1:0] src_use;
  logic [NSRC-1:0] src_ok;
  logic            set_en;

  assign src_idx[0] = src_a;
  assign src_idx[1] = src_b;
  assign src_use    = {src_b_use, src_a_use};

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      sb_src_check #(.NREG(NREG), .AW(AW), .NWP(NWP)) chk_i (
        .clk     (clk),
        .rst     (rst),
        .src_idx (src_idx[s]),
        .src_use (src_use[s]),
        .busy    (busy_vec),
        .wb_en   (wb_en),
        .wb_reg  (wb_reg),
        .src_ok  (src_ok[s])
      );
    end
  endgenerate

  assign ops_ready   = &src_ok;
  assign issue_grant = issue_req && ops_ready;
  assign set_en      = issue_grant && dst_use;

  sb_busy_bank #(.NREG(NREG), .AW(AW), .NWP(NWP)) bank_i (
    .clk     (clk),
    .rst     (rst),
    .set_en  (set_en),
    .set_idx (dst),
    .clr_en  (wb_en),
    .clr_idx (wb_reg),
    .busy    (busy_vec)
  );

  assert_nogrant_R9: assert property (@(posedge clk) disable iff (rst)
    (!issue_grant && (wb_en == '0)) |=> (busy_vec == $past(busy_vec)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_req && !ops_ready && (wb_en == '0)) |=> $stable(busy_vec));
endmodule

// File: tb/regscore_top_tb.sv
module regscore_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int AW   = 4;
  localparam int NWP  = 2;
  localparam int VW   = 27;
  localparam int NVEC = 13;

  // fields: issue, a, a_use, b, b_use, d, d_use, wb_en[1:0], wb0, wb1, expected ready
  localparam logic [VW-1:0] TBL [NVEC] = '{
    {1'b1, 4'd1,  1'b1, 4'd2, 1'b1, 4'd5,  1'b1, 2'b00, 4'd0,  4'd0, 1'b1}, // R2
    {1'b1, 4'd5,  1'b1, 4'd0, 1'b0, 4'd6,  1'b1, 2'b00, 4'd0,  4'd0, 1'b0}, // R4
    {1'b1, 4'd5,  1'b1, 4'd0, 1'b0, 4'd6,  1'b1, 2'b01, 4'd5,  4'd0, 1'b1}, // R5 port0
    {1'b1, 4'd3,  1'b1, 4'd6, 1'b1, 4'd7,  1'b1, 2'b10, 4'd0,  4'd6, 1'b1}, // R5 port1
    {1'b1, 4'd7,  1'b0, 4'd7, 1'b0, 4'd15, 1'b1, 2'b00, 4'd0,  4'd0, 1'b1}, // R6
    {1'b1, 4'd0,  1'b1, 4'd0, 1'b1, 4'd0,  1'b1, 2'b00, 4'd0,  4'd0, 1'b1}, // R7
    {1'b1, 4'd15, 1'b1, 4'd1, 1'b1, 4'd7,  1'b1, 2'b01, 4'd7,  4'd0, 1'b0}, // R4
    {1'b0, 4'd15, 1'b1, 4'd0, 1'b0, 4'd2,  1'b1, 2'b01, 4'd15, 4'd0, 1'b1}, // R9
    {1'b1, 4'd1,  1'b1, 4'd2, 1'b1, 4'd9,  1'b1, 2'b01, 4'd9,  4'd0, 1'b1}, // R8
    {1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 2'b11, 4'd9,  4'd3, 1'b1}, // R3
    {1'b1, 4'd0,  1'b0, 4'd0, 1'b0, 4'd4,  1'b1, 2'b00, 4'd0,  4'd0, 1'b1}, // R2
    {1'b1, 4'd0,  1'b0, 4'd0, 1'b0, 4'd8,  1'b1, 2'b00, 4'd0,  4'd0, 1'b1}, // R2
    {1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 2'b11, 4'd4,  4'd8, 1'b1}  // R3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_req = 1'b0;
  logic [AW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic src_a_use = 1'b0, src_b_use = 1'b0, dst_use = 1'b0;
  logic [NWP-1:0] wb_en = '0;
  logic [NWP*AW-1:0] wb_reg = '0;
  logic ops_ready, issue_grant;
  logic [NREG-1:0] busy_vec;

  int checks = 0;
  int fails  = 0;
  logic [NREG-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regscore_top #(.NREG(NREG), .AW(AW), .NWP(NWP)) dut_i (
    .clk(clk), .rst(rst), .issue_req(issue_req),
    .src_a(src_a), .src_a_use(src_a_use), .src_b(src_b), .src_b_use(src_b_use),
    .dst(dst), .dst_use(dst_use), .wb_en(wb_en), .wb_reg(wb_reg),
    .ops_ready(ops_ready), .issue_grant(issue_grant), .busy_vec(busy_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 32'(busy_vec), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [VW-1:0] e;
      logic exp_g;
      e = TBL[v];
      issue_req = e[26]; src_a = e[25:22]; src_a_use = e[21];
      src_b = e[20:17]; src_b_use = e[16]; dst = e[15:12]; dst_use = e[11];
      wb_en = e[10:9]; wb_reg = {e[4:1], e[8:5]};
      #1;
      exp_g = e[26] & e[0];
      check("R4/R5/R6/R7 ops_ready", 32'(ops_ready), 32'(e[0]));
      check("R9 issue_grant", 32'(issue_grant), 32'(exp_g));
      if (e[9])  model[e[8:5]] = 1'b0;
      if (e[10]) model[e[4:1]] = 1'b0;
      if (exp_g && e[11] && (e[15:12] != 0)) model[e[15:12]] = 1'b1;
      @(posedge clk);
      #1;
      check("R2/R3/R8 busy_vec", 32'(busy_vec), 32'(model));
      @(negedge clk);
    end

    // R2 boundary: top register flagged, then R1 reset while an issue is granted
    issue_req = 1'b1; src_a_use = 1'b0; src_b_use = 1'b0;
    dst = 4'd15; dst_use = 1'b1; wb_en = '0;
    @(posedge clk); #1;
    check("R2 top register set", 32'(busy_vec), 32'h8000);
    @(negedge clk);
    dst = 4'd3; rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset with grant", 32'(busy_vec), 32'd0);
    @(negedge clk);
    rst = 1'b0; issue_req = 1'b0; dst_use = 1'b0;
    @(posedge clk); #1;
    check("R9 idle no set", 32'(busy_vec), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule